// File: doc/BRIEF.md
# I2C Expander Register-Access Monitor

This block sits behind an I2C event decoder and watches traffic aimed at a small 8-bit I/O expander. It never touches the bus. Each clock it may take one decoded event: a kind code plus the byte that came with it. From that stream it follows each transaction. It learns the slave address, latches the register pointer that the master writes first, and then credits later writes, or reads after a repeated start, to that pointer.

Every access becomes a one-cycle record on the output side. A record holds its kind (pointer select, write or read), the register index, the data byte, and a flag that marks an index beyond the expander's register set. When an address event in the pointer phase names a slave outside the compatible pair, the monitor raises a one-cycle warning that carries the offending address and drops back to idle. The tracked slave address is always visible on its own output.

Top module: `xmon_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `rec_valid` and `warn_valid` are 0 and `mon_addr` holds the invalid marker 0xFF.
- R2: Event codes on `ev_kind` are 0 start, 1 repeated start, 2 stop, 3 address-write, 4 address-read, 5 data-write and 6 data-read. In idle, every event other than start is ignored: it produces no record, no warning and no change to `mon_addr`.
- R3: After a start, the byte of the next event, whatever its kind, becomes `mon_addr`, and the monitor then waits for the register pointer.
- R4: In the pointer phase, a data-write latches its byte as the register pointer and emits a record of kind 0 (select) with `rec_reg` and `rec_data` both equal to that byte. Record kinds are 0 select, 1 write and 2 read.
- R5: In the pointer phase, an address-write or address-read whose byte is neither 0x20 nor 0x21 gives `warn_valid`=1 with `warn_addr` equal to the byte and returns the monitor to idle. A byte of 0x20 or 0x21 gives no warning and leaves the pointer phase in place.
- R6: In the write phase, each data-write emits a record of kind 1 with `rec_reg` equal to the latched pointer and `rec_data` equal to the byte.
- R7: A repeated start in the write phase enters a read wait. There every event is ignored except address-read, which loads `mon_addr` from its byte. Each data-read that follows emits a record of kind 2 with the latched pointer and the byte.
- R8: A stop in the write phase returns to idle and sets `mon_addr` to 0xFF. A stop in the read phase returns to idle and keeps `mon_addr`.
- R9: `rec_bad` is 1 on exactly those records whose `rec_reg` exceeds 3 (registers 0 input, 1 output, 2 polarity, 3 configuration). Such records are still emitted and tracking continues.
- R10: A record or warning appears in the cycle right after the clock edge that accepts its event and lasts one cycle. A cycle with `ev_valid` low produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event strobe, one event per cycle |
| ev_kind | input | 3 | Event code |
| ev_byte | input | 8 | Byte carried by the event |
| rec_valid | output | 1 | Access record strobe |
| rec_kind | output | 2 | Record kind: select, write, read |
| rec_reg | output | 8 | Register index of the record |
| rec_data | output | 8 | Data byte of the record |
| rec_bad | output | 1 | Register index outside the register set |
| warn_valid | output | 1 | Incompatible slave warning strobe |
| warn_addr | output | 8 | Address that caused the warning |
| mon_addr | output | 8 | Currently tracked slave address |

## Verification
Records and warnings are registered once, so each is due in the cycle right after the rising edge that accepts its event. `mon_addr` changes at that same edge. The bench drives each event on a falling edge and holds it across exactly one rising edge. It then reads every output on the next falling edge, before it drives the next event, so each check sees precisely the result of the event just sent. Idle cycles with the strobe low are checked the same way to show that nothing is emitted.

// File: rtl/xmon_pkg.sv
package xmon_pkg;

   typedef enum logic [2:0] {
      EV_START   = 3'd0,
      EV_RESTART = 3'd1,
      EV_STOP    = 3'd2,
      EV_ADDR_WR = 3'd3,
      EV_ADDR_RD = 3'd4,
      EV_DATA_WR = 3'd5,
      EV_DATA_RD = 3'd6
   } ev_kind_e;

   typedef enum logic [1:0] {
      RK_SELECT = 2'd0,
      RK_WRITE  = 2'd1,
      RK_READ   = 2'd2
   } rec_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PTR,
      ST_WR,
      ST_RD_WAIT,
      ST_RD
   } mon_state_e;

endpackage

// File: rtl/xmon_addr_match.sv
module xmon_addr_match #(
   parameter int DATA_W = 8,
   parameter int BASE   = 32,
   parameter int COUNT  = 2
) (
   input  logic [DATA_W-1:0] addr,
   output logic              ok
);
   localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 0;
   localparam bit POW2 = (COUNT == (1 << CW));
   localparam bit ALIGNED = POW2 && ((BASE % COUNT) == 0);
   localparam logic [DATA_W-1:0] BASE_V = DATA_W'(BASE);
   localparam logic [DATA_W:0] LIMIT_V = (DATA_W+1)'(BASE + COUNT);

   if (COUNT < 1) begin : g_bad_count
      $error("xmon_addr_match: COUNT must be at least 1");
   end
   if (BASE + COUNT > (1 << DATA_W)) begin : g_bad_range
      $error("xmon_addr_match: address window exceeds DATA_W");
   end

   if (ALIGNED && CW < DATA_W) begin : g_mask
      // Aligned power-of-two window: compare only the upper bits.
      assign ok = (addr[DATA_W-1:CW] == BASE_V[DATA_W-1:CW]);
   end else begin : g_range
      // Arbitrary window: two magnitude compares.
      assign ok = (addr >= BASE_V) && ({1'b0, addr} < LIMIT_V);
   end
endmodule

// File: rtl/xmon_reg_class.sv
module xmon_reg_class #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 4
) (
   input  logic [DATA_W-1:0] reg_idx,
   output logic              bad
);
   localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 0;
   localparam bit POW2 = (NUM_REGS == (1 << IW));

   if (NUM_REGS < 1) begin : g_bad_regs
      $error("xmon_reg_class: NUM_REGS must be at least 1");
   end

   if (POW2 && IW >= DATA_W) begin : g_all_valid
      assign bad = 1'b0;
   end else if (POW2) begin : g_upper_bits
      // Power-of-two register set: any set upper bit is out of range.
      assign bad = |reg_idx[DATA_W-1:IW];
   end else begin : g_compare
      assign bad = (reg_idx >= DATA_W'(NUM_REGS));
   end
endmodule

// File: rtl/xmon_seq.sv
module xmon_seq
   import xmon_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] ADDR_NONE = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_valid,
   input  logic [2:0]        ev_kind,
   input  logic [DATA_W-1:0] ev_byte,
   input  logic              addr_ok,
   output logic              emit_rec,
   output logic [1:0]        emit_kind,
   output logic [DATA_W-1:0] emit_reg,
   output logic              emit_warn,
   output logic [DATA_W-1:0] addr_q
);
   mon_state_e        state_q, state_d;
   logic [DATA_W-1:0] addr_d;
   logic [DATA_W-1:0] ptr_q, ptr_d;
   ev_kind_e          kind;
   logic              is_addr_ev;

   assign kind       = ev_kind_e'(ev_kind);
   assign is_addr_ev = (kind == EV_ADDR_WR) || (kind == EV_ADDR_RD);

   always_comb begin
      state_d   = state_q;
      addr_d    = addr_q;
      ptr_d     = ptr_q;
      emit_rec  = 1'b0;
      emit_kind = RK_SELECT;
      emit_reg  = ptr_q;
      emit_warn = 1'b0;
      if (ev_valid) begin
         case (state_q)
            ST_IDLE: begin
               if (kind == EV_START) state_d = ST_ADDR;
            end
            ST_ADDR: begin
               addr_d  = ev_byte;
               state_d = ST_PTR;
            end
            ST_PTR: begin
               if (is_addr_ev && !addr_ok) begin
                  emit_warn = 1'b1;
                  state_d   = ST_IDLE;
               end else if (kind == EV_DATA_WR) begin
                  ptr_d     = ev_byte;
                  emit_rec  = 1'b1;
                  emit_kind = RK_SELECT;
                  emit_reg  = ev_byte;
                  state_d   = ST_WR;
               end
            end
            ST_WR: begin
               if (kind == EV_RESTART) begin
                  state_d = ST_RD_WAIT;
               end else if (kind == EV_DATA_WR) begin
                  emit_rec  = 1'b1;
                  emit_kind = RK_WRITE;
               end else if (kind == EV_STOP) begin
                  state_d = ST_IDLE;
                  addr_d  = ADDR_NONE;
               end
            end
            ST_RD_WAIT: begin
               if (kind == EV_ADDR_RD) begin
                  addr_d  = ev_byte;
                  state_d = ST_RD;
               end
            end
            ST_RD: begin
               if (kind == EV_DATA_RD) begin
                  emit_rec  = 1'b1;
                  emit_kind = RK_READ;
               end else if (kind == EV_STOP) begin
                  state_d = ST_IDLE;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= ADDR_NONE;
         ptr_q   <= '0;
      end else begin
         state_q <= state_d;
         addr_q  <= addr_d;
         ptr_q   <= ptr_d;
      end
   end

   // R2: idle ignores everything but a start
   a_r2_idle_ignores: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && ev_valid && kind != EV_START)
      |=> (state_q == ST_IDLE && $stable(addr_q)));

   // R5: a warning always leaves the monitor idle
   a_r5_warn_to_idle: assert property (@(posedge clk) disable iff (rst)
      emit_warn |=> (state_q == ST_IDLE));

   // R7: read wait holds until an address-read arrives
   a_r7_wait_holds: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_RD_WAIT && !(ev_valid && kind == EV_ADDR_RD))
      |=> (state_q == ST_RD_WAIT && $stable(addr_q)));

   // R8: stop in the write phase clears the tracked address
   a_r8_stop_clears: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WR && ev_valid && kind == EV_STOP)
      |=> (state_q == ST_IDLE && addr_q == ADDR_NONE));

   // R8: stop in the read phase keeps the tracked address
   a_r8_stop_keeps: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_RD && ev_valid && kind == EV_STOP)
      |=> (state_q == ST_IDLE && $stable(addr_q)));
endmodule

// File: rtl/xmon_rec_out.sv
module xmon_rec_out
   import xmon_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              emit_rec,
   input  logic [1:0]        emit_kind,
   input  logic [DATA_W-1:0] emit_reg,
   input  logic [DATA_W-1:0] emit_data,
   input  logic              emit_bad,
   input  logic              emit_warn,
   input  logic [DATA_W-1:0] warn_byte,
   output logic              rec_valid,
   output logic [1:0]        rec_kind,
   output logic [DATA_W-1:0] rec_reg,
   output logic [DATA_W-1:0] rec_data,
   output logic              rec_bad,
   output logic              warn_valid,
   output logic [DATA_W-1:0] warn_addr
);
   always_ff @(posedge clk) begin
      if (rst) begin
         rec_valid  <= 1'b0;
         rec_kind   <= RK_SELECT;
         rec_reg    <= '0;
         rec_data   <= '0;
         rec_bad    <= 1'b0;
         warn_valid <= 1'b0;
         warn_addr  <= '0;
      end else begin
         rec_valid  <= emit_rec;
         warn_valid <= emit_warn;
         if (emit_rec) begin
            rec_kind <= emit_kind;
            rec_reg  <= emit_reg;
            rec_data <= emit_data;
            rec_bad  <= emit_bad;
         end
         if (emit_warn) warn_addr <= warn_byte;
      end
   end

   // R10: records and warnings never coincide (one event per cycle)
   a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rec_valid, warn_valid}));

   // R10: a record appears only after a cycle that produced one
   a_r10_from_emit: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> $past(emit_rec));

   // R9: a record without the flag names a register in the set
   a_r9_flag_range: assert property (@(posedge clk) disable iff (rst)
      (rec_valid && !rec_bad) |-> (rec_reg < DATA_W'(NUM_REGS)));
endmodule

// File: rtl/xmon_top.sv
module xmon_top
   import xmon_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter int                NUM_REGS   = 4,
   parameter int                ADDR_BASE  = 32,
   parameter int                ADDR_COUNT = 2,
   parameter logic [DATA_W-1:0] ADDR_NONE  = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_valid,
   input  logic [2:0]        ev_kind,
   input  logic [DATA_W-1:0] ev_byte,
   output logic              rec_valid,
   output logic [1:0]        rec_kind,
   output logic [DATA_W-1:0] rec_reg,
   output logic [DATA_W-1:0] rec_data,
   output logic              rec_bad,
   output logic              warn_valid,
   output logic [DATA_W-1:0] warn_addr,
   output logic [DATA_W-1:0] mon_addr
);
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
      $error("xmon_top: DATA_W out of range");
   end
   if (NUM_REGS > (1 << DATA_W)) begin : g_bad_regs
      $error("xmon_top: NUM_REGS exceeds index space");
   end

   logic              addr_ok;
   logic              emit_rec;
   logic [1:0]        emit_kind;
   logic [DATA_W-1:0] emit_reg;
   logic              emit_warn;
   logic              emit_bad;

   xmon_addr_match #(
      .DATA_W (DATA_W),
      .BASE   (ADDR_BASE),
      .COUNT  (ADDR_COUNT)
   ) u_match (
      .addr (ev_byte),
      .ok   (addr_ok)
   );

   xmon_seq #(
      .DATA_W    (DATA_W),
      .ADDR_NONE (ADDR_NONE)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .ev_valid  (ev_valid),
      .ev_kind   (ev_kind),
      .ev_byte   (ev_byte),
      .addr_ok   (addr_ok),
      .emit_rec  (emit_rec),
      .emit_kind (emit_kind),
      .emit_reg  (emit_reg),
      .emit_warn (emit_warn),
      .addr_q    (mon_addr)
   );

   xmon_reg_class #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_class (
      .reg_idx (emit_reg),
      .bad     (emit_bad)
   );

   xmon_rec_out #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_out (
      .clk        (clk),
      .rst        (rst),
      .emit_rec   (emit_rec),
      .emit_kind  (emit_kind),
      .emit_reg   (emit_reg),
      .emit_data  (ev_byte),
      .emit_bad   (emit_bad),
      .emit_warn  (emit_warn),
      .warn_byte  (ev_byte),
      .rec_valid  (rec_valid),
      .rec_kind   (rec_kind),
      .rec_reg    (rec_reg),
      .rec_data   (rec_data),
      .rec_bad    (rec_bad),
      .warn_valid (warn_valid),
      .warn_addr  (warn_addr)
   );

   // R1: outputs are quiet in the cycle after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $fell(rst) |-> (!rec_valid && !warn_valid && mon_addr == ADDR_NONE));
endmodule

// File: tb/xmon_top_test.sv
`timescale 1ns/1ps
module xmon_top_test;
   localparam logic [2:0] K_START = 3'd0, K_RESTART = 3'd1, K_STOP = 3'd2,
                          K_AWR = 3'd3, K_ARD = 3'd4, K_DWR = 3'd5, K_DRD = 3'd6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ev_valid = 1'b0;
   logic [2:0] ev_kind = 3'd0;
   logic [7:0] ev_byte = 8'd0;
   logic       rec_valid, rec_bad, warn_valid;
   logic [1:0] rec_kind;
   logic [7:0] rec_reg, rec_data, warn_addr, mon_addr;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   xmon_top uut (
      .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_byte(ev_byte), .rec_valid(rec_valid), .rec_kind(rec_kind),
      .rec_reg(rec_reg), .rec_data(rec_data), .rec_bad(rec_bad),
      .warn_valid(warn_valid), .warn_addr(warn_addr), .mon_addr(mon_addr)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive on a falling edge, hold across one rising edge, return on the next falling edge
   task automatic ev(input logic [2:0] k, input logic [7:0] b);
      ev_valid = 1'b1;
      ev_kind  = k;
      ev_byte  = b;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic gap();
      @(negedge clk);
   endtask

   task automatic chk_rec(input string tag, input logic [1:0] k,
                          input logic [7:0] r, input logic [7:0] d);
      logic [19:0] act, exp;
      act = {rec_valid, rec_kind, rec_bad, rec_reg, rec_data};
      exp = {1'b1, k, (r > 8'd3), r, d};
      chk(act == exp && !warn_valid, tag, 32'(act), 32'(exp));
   endtask

   task automatic chk_none(input string tag);
      chk(!rec_valid && !warn_valid, tag,
          32'({rec_valid, warn_valid}), 32'd0);
   endtask

   task automatic chk_addr(input string tag, input logic [7:0] a);
      chk(mon_addr == a, tag, 32'(mon_addr), 32'(a));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk_none("R1 outputs during reset");
      chk_addr("R1 address during reset", 8'hFF);
      rst = 1'b0;
      @(negedge clk);
      chk_none("R1 outputs after reset");
      chk_addr("R1 address after reset", 8'hFF);

      // R2: every non-start kind is ignored in idle
      for (int k = 1; k <= 6; k++) begin
         ev(3'(k), 8'(8'h20 + k));
         chk_none($sformatf("R2 idle kind %0d", k));
         chk_addr($sformatf("R2 idle kind %0d addr", k), 8'hFF);
      end

      // R3 R4 R6 R8 R9: write transactions over pointers 0..7
      for (int p = 0; p < 8; p++) begin
         logic [7:0] d1, d2;
         d1 = 8'(p * 17 + 3);
         d2 = 8'(8'hA5 ^ p);
         ev(K_START, 8'h00);
         chk_none("R3 start");
         ev(K_AWR, 8'(8'h40 + p));
         chk_none("R3 address capture quiet");
         chk_addr("R3 address captured", 8'(8'h40 + p));
         ev(K_DWR, 8'(p));
         chk_rec($sformatf("R4 R9 select p=%0d", p), 2'd0, 8'(p), 8'(p));
         ev(K_DWR, d1);
         chk_rec($sformatf("R6 R9 write p=%0d", p), 2'd1, 8'(p), d1);
         gap();
         chk_none("R10 idle strobe gives no record");
         ev(K_DWR, d2);
         chk_rec($sformatf("R6 second write p=%0d", p), 2'd1, 8'(p), d2);
         ev(K_STOP, 8'h00);
         chk_none("R8 stop quiet");
         chk_addr("R8 write stop clears address", 8'hFF);
      end

      // R7 R8: read transactions
      for (int p = 0; p < 8; p++) begin
         logic [7:0] v;
         v = 8'(8'h3C + p * 5);
         ev(K_START, 8'h00);
         ev(K_AWR, 8'h20);
         ev(K_DWR, 8'(p));
         chk_rec("R4 select before read", 2'd0, 8'(p), 8'(p));
         ev(K_RESTART, 8'h00);
         chk_none("R7 restart quiet");
         ev(K_DRD, 8'h99);
         chk_none("R7 data-read ignored in wait");
         ev(K_DWR, 8'h77);
         chk_none("R7 data-write ignored in wait");
         ev(K_STOP, 8'h00);
         chk_none("R7 stop ignored in wait");
         chk_addr("R7 wait keeps address", 8'h20);
         ev(K_ARD, 8'(8'h50 + p));
         chk_none("R7 address-read quiet");
         chk_addr("R7 address-read loads address", 8'(8'h50 + p));
         ev(K_DRD, v);
         chk_rec($sformatf("R7 R9 read p=%0d", p), 2'd2, 8'(p), v);
         ev(K_DRD, ~v);
         chk_rec($sformatf("R10 back-to-back read p=%0d", p), 2'd2, 8'(p), ~v);
         ev(K_STOP, 8'h00);
         chk_none("R8 read stop quiet");
         chk_addr("R8 read stop keeps address", 8'(8'h50 + p));
         ev(K_DWR, 8'h01);
         chk_none("R8 idle after read stop");
      end

      // R5: sweep every address through an address event in the pointer phase
      for (int a = 0; a < 256; a++) begin
         bit good;
         good = (a == 32'h20) || (a == 32'h21);
         ev(K_START, 8'h00);
         ev(K_AWR, 8'h20);
         ev((a % 2 == 0) ? K_ARD : K_AWR, 8'(a));
         if (good) begin
            chk_none($sformatf("R5 compatible 0x%02h no warning", a));
         end else begin
            chk(warn_valid && !rec_valid && warn_addr == 8'(a),
                $sformatf("R5 warning for 0x%02h", a),
                32'({warn_valid, rec_valid, warn_addr}),
                32'({1'b1, 1'b0, 8'(a)}));
         end
         ev(K_DWR, 8'h02);
         if (good) chk_rec("R5 tracking continues", 2'd0, 8'h02, 8'h02);
         else      chk_none("R5 warning forced idle");
         ev(K_STOP, 8'h00);
         chk_none("R5 closing stop");
      end

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule